// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending side of a serial port. Software writes characters over a simple write strobe into a one-entry holding register. A separate shift stage turns each character into a frame on a single data line. A frame holds a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Two timing regimes are supported. In asynchronous mode, an enable pulse arrives at sixteen times the baud rate, and every bit lasts sixteen such pulses. The final stop bit can be shortened to fourteen pulses. In synchronous mode, each pulse marks a rising edge of the bit clock, and each bit lasts exactly one pulse. While one character is on the line, the next can already sit in the holding register. It then follows with no idle gap. A buffer-empty flag and a busy flag show the state of the two stages.

Top module: `usart_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `buf_empty` is 1.
- R2: Frames start on a strobe only, and only when the holding register is full and the shift stage is idle or ending its frame. A frame is a start bit at 0, then data bits LSB first, then stop bits at 1. While `busy` is 0 the line is 1.
- R3: `fmt_sel` selects the data length. 2'b00 gives 8 bits. 2'b01 gives 7 bits, taken from `wr_data[6:0]`. 2'b10 and 2'b11 give 9 bits.
- R4: In the 7-bit and 8-bit formats, `par_en`=1 adds one bit after the data. `par_sel` selects its value: 00 makes the count of ones odd, 01 makes it even, 10 gives a constant 1 and 11 gives a constant 0.
- R5: In the 9-bit format, the ninth data bit equals `par_sel[0]`, and no parity bit is sent whatever the value of `par_en`.
- R6: `two_stop`=1 sends two stop bits, otherwise one is sent. In asynchronous mode a bit lasts 16 ticks. With `short_stop`=1 only the last stop bit lasts 14 ticks.
- R7: With `sync_mode`=1, each `sclk_rise` pulse is one bit time, and `os_tick` and `short_stop` have no effect. With `sync_mode`=0, `sclk_rise` has no effect.
- R8: A character written while a frame is on the line begins its own frame on the strobe that ends the last stop bit, with no gap between the frames. `buf_empty` goes to 1 when the character moves into the shift stage.
- R9: A write clears `buf_empty`. A write while the holding register is full replaces the pending character.
- R10: `busy` rises when a frame is loaded. It falls only on the strobe that ends the last stop bit of the final queued frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 selects bit-clock timing, 0 selects 16x oversampled timing |
| os_tick | input | 1 | One-cycle pulse at 16x the baud rate (asynchronous mode) |
| sclk_rise | input | 1 | One-cycle pulse per rising bit-clock edge (synchronous mode) |
| fmt_sel | input | 2 | Data length select |
| par_en | input | 1 | Parity enable for the 7-bit and 8-bit formats |
| par_sel | input | 2 | Parity kind; bit 0 is the ninth data bit in the 9-bit format |
| two_stop | input | 1 | Two stop bits when 1 |
| short_stop | input | 1 | Last stop bit at 7/8 length (asynchronous mode) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding register is free |
| busy | output | 1 | A frame is being sent |

## Verification
The assertions assume the following about the inputs:
- `os_tick` and `sclk_rise` are single-cycle pulses.
- `sync_mode` does not change while a frame is on the line, because the strobe it selects is what moves the line.
- Format inputs matter only on the loading strobe.

The stimulus meets these assumptions in several ways. It changes the configuration only when the transmitter is idle. It raises each strobe for one cycle, with random idle cycles between strobes. It drives the strobe of the unused mode at random, which checks that this strobe is ignored. Writes fall between strobes, except in the directed cases that overwrite a pending character.

// File: rtl/usart_tx_pkg.sv
`timescale 1ns/1ps
package usart_tx_pkg;

  localparam int CHAR_W = 8;
  localparam int PAY_W  = CHAR_W + 2;        // start + up to 9 data/parity
  localparam int POS_W  = $clog2(PAY_W + 3); // covers the two stop positions

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_kind_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic       par_en;
    logic [1:0] par_sel;
    logic       two_stop;
    logic       short_stop;
  } frame_cfg_t;

  function automatic int data_bits(input logic [1:0] fmt);
    if (fmt[1])      return CHAR_W + 1;
    else if (fmt[0]) return CHAR_W - 1;
    else             return CHAR_W;
  endfunction

  function automatic logic has_parity(input frame_cfg_t c);
    return c.par_en && !c.fmt[1];
  endfunction

  function automatic logic parity_bit(input logic [CHAR_W-1:0] d,
                                      input logic seven,
                                      input logic [1:0] sel);
    logic ones;
    ones = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (!(seven && i == CHAR_W - 1)) ones = ones ^ d[i];
    case (par_kind_e'(sel))
      PAR_ODD:  return ~ones;
      PAR_EVEN: return ones;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] payload_len(input frame_cfg_t c);
    return POS_W'(1 + data_bits(c.fmt) + (has_parity(c) ? 1 : 0));
  endfunction

  function automatic logic [PAY_W-1:0] build_payload(input logic [CHAR_W-1:0] d,
                                                     input frame_cfg_t c);
    logic [PAY_W-1:0] p;
    int nd;
    nd   = data_bits(c.fmt);
    p    = '1;
    p[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (i < nd) p[i+1] = d[i];
    if (c.fmt[1])
      p[CHAR_W+1] = c.par_sel[0];
    else if (c.par_en)
      p[nd+1] = parity_bit(d, c.fmt[0], c.par_sel);
    return p;
  endfunction

endpackage

// File: rtl/usart_tx_hold.sv
`timescale 1ns/1ps
module usart_tx_hold
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic [CHAR_W-1:0] hold_q,
  output logic              full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full   <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_q <= wr_data;
        full   <= 1'b1;
      end else if (take) begin
        full   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usart_tx_framer.sv
`timescale 1ns/1ps
module usart_tx_framer
  import usart_tx_pkg::*;
(
  input  logic [CHAR_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic [PAY_W-1:0]  payload,
  output logic [POS_W-1:0]  pay_len,
  output logic [POS_W-1:0]  last_pos
);

  always_comb begin
    payload  = build_payload(data, cfg);
    pay_len  = payload_len(cfg);
    last_pos = pay_len + POS_W'(cfg.two_stop);
  end

endmodule

// File: rtl/usart_tx_shifter.sv
`timescale 1ns/1ps
module usart_tx_shifter
  import usart_tx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SHORT_TICKS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             sync_mode,
  input  logic             start_req,
  input  logic [PAY_W-1:0] payload_in,
  input  logic [POS_W-1:0] pay_len_in,
  input  logic [POS_W-1:0] last_in,
  input  logic             short_in,
  output logic             take,
  output logic             frame_end,
  output logic             busy,
  output logic             txd
);

  localparam int TC_W = $clog2(OVS + 1);

  logic             active_q;
  logic [PAY_W-1:0] pay_q;
  logic [POS_W-1:0] npay_q;
  logic [POS_W-1:0] last_q;
  logic             short_q;
  logic [POS_W-1:0] pos_q;
  logic [TC_W-1:0]  tcnt_q;

  logic [TC_W-1:0]  bit_len;
  logic             bit_done;
  logic [PAY_W-1:0] pay_sh;

  always_comb begin
    if (sync_mode)                     bit_len = TC_W'(1);
    else if (pos_q == last_q && short_q) bit_len = TC_W'(SHORT_TICKS);
    else                               bit_len = TC_W'(OVS);
  end

  assign bit_done  = active_q && stb && (tcnt_q == bit_len - 1'b1);
  assign frame_end = bit_done && (pos_q == last_q);
  assign take      = stb && start_req && (!active_q || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pay_q    <= '1;
      npay_q   <= '0;
      last_q   <= '0;
      short_q  <= 1'b0;
      pos_q    <= '0;
      tcnt_q   <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      pay_q    <= payload_in;
      npay_q   <= pay_len_in;
      last_q   <= last_in;
      short_q  <= short_in;
      pos_q    <= '0;
      tcnt_q   <= '0;
    end else if (frame_end) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      tcnt_q   <= '0;
    end else if (bit_done) begin
      pos_q    <= pos_q + 1'b1;
      tcnt_q   <= '0;
    end else if (active_q && stb) begin
      tcnt_q   <= tcnt_q + 1'b1;
    end
  end

  assign pay_sh = pay_q >> pos_q;
  assign busy   = active_q;
  assign txd    = !active_q ? 1'b1 : ((pos_q < npay_q) ? pay_sh[0] : 1'b1);

endmodule

// File: rtl/usart_tx.sv
`timescale 1ns/1ps
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SHORT_TICKS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              os_tick,
  input  logic              sclk_rise,
  input  logic [1:0]        fmt_sel,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic              two_stop,
  input  logic              short_stop,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              busy
);

  frame_cfg_t       cfg;
  logic             stb;
  logic             load_evt;
  logic             frame_end;
  logic             hold_full;
  logic [CHAR_W-1:0] hold_q;
  logic [PAY_W-1:0] payload;
  logic [POS_W-1:0] pay_len;
  logic [POS_W-1:0] last_pos;

  assign cfg = '{fmt: fmt_sel, par_en: par_en, par_sel: par_sel,
                 two_stop: two_stop, short_stop: short_stop};
  assign stb = sync_mode ? sclk_rise : os_tick;

  usart_tx_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load_evt),
    .hold_q  (hold_q),
    .full    (hold_full)
  );

  usart_tx_framer u_framer (
    .data     (hold_q),
    .cfg      (cfg),
    .payload  (payload),
    .pay_len  (pay_len),
    .last_pos (last_pos)
  );

  usart_tx_shifter #(.OVS(OVS), .SHORT_TICKS(SHORT_TICKS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .sync_mode  (sync_mode),
    .start_req  (hold_full),
    .payload_in (payload),
    .pay_len_in (pay_len),
    .last_in    (last_pos),
    .short_in   (short_stop),
    .take       (load_evt),
    .frame_end  (frame_end),
    .busy       (busy),
    .txd        (txd)
  );

  assign buf_empty = !hold_full;

endmodule

// File: rtl/usart_tx_chk.sv
`timescale 1ns/1ps
module usart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic stb,
  input logic load_evt,
  input logic frame_end,
  input logic wr_en,
  input logic txd,
  input logic busy,
  input logic buf_empty
);

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd && busy));

  p_line_moves_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(txd) && $stable(busy)));

  p_load_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> buf_empty);

  p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  p_busy_ends_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_end));

  p_busy_starts_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_evt));

endmodule

bind usart_tx usart_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stb       (stb),
  .load_evt  (load_evt),
  .frame_end (frame_end),
  .wr_en     (wr_en),
  .txd       (txd),
  .busy      (busy),
  .buf_empty (buf_empty)
);

// File: tb/usart_tx_test.sv
`timescale 1ns/1ps
module usart_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       os_tick = 1'b0;
  logic       sclk_rise = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       two_stop = 1'b0;
  logic       short_stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, buf_empty, busy;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  bit  exp_lv [0:1023];
  int  exp_n = 0;
  int  seed_dummy;

  usart_tx uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .os_tick(os_tick),
    .sclk_rise(sclk_rise), .fmt_sel(fmt_sel), .par_en(par_en),
    .par_sel(par_sel), .two_stop(two_stop), .short_stop(short_stop),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty),
    .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] f);
    return (f == 2'b01) ? 7 : ((f == 2'b00) ? 8 : 9);
  endfunction

  task automatic push(input bit v, input int len);
    for (int k = 0; k < len; k++) begin
      exp_lv[exp_n] = v;
      exp_n++;
    end
  endtask

  // expected line levels, one per strobe, from the requirements
  task automatic append_frame(input logic [7:0] d);
    int nd, ones, full, last_len;
    nd       = nbits(fmt_sel);
    full     = sync_mode ? 1 : 16;
    last_len = sync_mode ? 1 : (short_stop ? 14 : 16);
    push(1'b0, full);
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      bit b;
      b = (i == 8) ? par_sel[0] : d[i];
      if (i < 8 && b) ones++;
      push(b, full);
    end
    if (nd != 9 && par_en) begin
      bit pb;
      case (par_sel)
        2'b00:   pb = (ones % 2 == 0);
        2'b01:   pb = (ones % 2 == 1);
        2'b10:   pb = 1'b1;
        default: pb = 1'b0;
      endcase
      push(pb, full);
    end
    if (two_stop) push(1'b1, full);
    push(1'b1, last_len);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(output bit t, output bit b, output bit e);
    @(negedge clk);
    if (sync_mode) begin
      sclk_rise = 1'b1;
      os_tick = 1'($urandom % 2);
    end else begin
      os_tick = 1'b1;
      sclk_rise = 1'($urandom % 2);
    end
    @(negedge clk);
    os_tick = 1'b0;
    sclk_rise = 1'b0;
    t = txd; b = busy; e = buf_empty;
    repeat ($urandom % 2) @(negedge clk);
  endtask

  task automatic check_seq(input int s0, input string req);
    bit t, b, e;
    int bad_at;
    bad_at = -1;
    for (int s = s0; s < exp_n; s++) begin
      strobe(t, b, e);
      if (bad_at < 0 && (t != exp_lv[s] || !b)) bad_at = s;
    end
    chk(bad_at < 0, req, "line level / busy during frame", bad_at, -1);
    strobe(t, b, e);
    chk(!b && t && e, "R10", "busy clear and line idle after last stop",
        int'({b, t, e}), 3);
  endtask

  task automatic set_cfg(input logic [1:0] f, input bit pe, input logic [1:0] ps,
                         input bit ts, input bit ss, input bit sy);
    @(negedge clk);
    fmt_sel = f; par_en = pe; par_sel = ps;
    two_stop = ts; short_stop = ss; sync_mode = sy;
  endtask

  task automatic one_frame(input logic [7:0] d, input string req);
    exp_n = 0;
    append_frame(d);
    do_write(d);
    chk(!buf_empty, "R9", "buf_empty after write", int'(buf_empty), 0);
    check_seq(0, req);
  endtask

  initial begin
    bit t, b, e;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd at reset", int'(txd), 1);
    chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
    chk(buf_empty == 1'b1, "R1", "buf_empty at reset", int'(buf_empty), 1);
    rst_n = 1'b1;

    // R2/R3 plain 8-bit frame, one stop
    set_cfg(2'b00, 0, 2'b00, 0, 0, 0);
    one_frame(8'hA5, "R2");
    // R3 7-bit: MSB of the write is not sent
    set_cfg(2'b01, 0, 2'b00, 0, 0, 0);
    one_frame(8'hC3, "R3");
    // R4 each parity kind, 8-bit and 7-bit
    set_cfg(2'b00, 1, 2'b00, 0, 0, 0); one_frame(8'h31, "R4");
    set_cfg(2'b00, 1, 2'b01, 0, 0, 0); one_frame(8'h31, "R4");
    set_cfg(2'b01, 1, 2'b10, 0, 0, 0); one_frame(8'h80, "R4");
    set_cfg(2'b01, 1, 2'b11, 0, 0, 0); one_frame(8'h7F, "R4");
    // R5 9-bit: ninth bit from par_sel[0], parity enable ignored
    set_cfg(2'b10, 1, 2'b01, 0, 0, 0); one_frame(8'h00, "R5");
    set_cfg(2'b11, 1, 2'b10, 0, 0, 0); one_frame(8'hFF, "R5");
    // R6 two stops with shortened last, and single short stop
    set_cfg(2'b00, 0, 2'b00, 1, 1, 0); one_frame(8'h5A, "R6");
    set_cfg(2'b00, 1, 2'b00, 0, 1, 0); one_frame(8'h12, "R6");
    // R7 sync mode: one strobe per bit, short stop ignored
    set_cfg(2'b00, 1, 2'b01, 1, 1, 1); one_frame(8'h96, "R7");
    set_cfg(2'b10, 0, 2'b11, 0, 1, 1); one_frame(8'h3C, "R7");

    // R7 async mode ignores sclk_rise pulses alone
    set_cfg(2'b00, 0, 2'b00, 0, 0, 0);
    exp_n = 0;
    append_frame(8'h69);
    do_write(8'h69);
    repeat (5) begin
      @(negedge clk); sclk_rise = 1'b1;
      @(negedge clk); sclk_rise = 1'b0;
    end
    chk(txd && !busy && !buf_empty, "R7", "sclk_rise ignored in async mode",
        int'({txd, busy, buf_empty}), 4);
    check_seq(0, "R7");

    // R8/R9 double buffering with an overwrite of the pending character
    set_cfg(2'b00, 1, 2'b00, 1, 1, 0);
    exp_n = 0;
    append_frame(8'h11);
    append_frame(8'hE7);
    do_write(8'h11);
    strobe(t, b, e);
    chk(!t && b && e, "R8", "load moves char and empties buffer",
        int'({t, b, e}), 3);
    do_write(8'h22);
    chk(!buf_empty, "R9", "write while busy fills buffer", int'(buf_empty), 0);
    do_write(8'hE7);
    chk(!buf_empty, "R9", "overwrite keeps buffer full", int'(buf_empty), 0);
    check_seq(1, "R8");

    // random frames
    for (int n = 0; n < 30; n++) begin
      set_cfg(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom % 4 == 0));
      one_frame(8'($urandom), "R2");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule